// File: doc/BRIEF.md
# Streaming Grid Stencil Time-Step Stage

This block advances a two-dimensional fixed-point field by one time step. Cells of a W-by-H grid arrive in raster order, one record per accepted handshake. Column index x runs fastest, then row index y. Every record holds the cell's present value, its previous value and a per-cell coefficient. That is all the block needs to update that cell. The output record keeps the same format, so identical stages can be chained, and stage k of a chain produces time step k.

Each of the four grid edges has its own boundary behaviour:

- **Fixed:** a neighbour outside the grid reads as zero.
- **Periodic:** the neighbour is taken from the opposite edge, which repeats the grid as a tile.

A wrapped neighbour can lie far later in the stream. For that reason the stage holds a complete frame in a delay store before it emits anything. Results leave in the same raster order in which the cells arrived.

The controller has two states:

- **FILL:** the input is ready and each accepted record is written to the store.
- **DRAIN:** the output is valid and the updated cells leave in raster order.

It has two transitions:

- **FILL_TO_DRAIN** is taken on acceptance of cell W*H-1.
- **DRAIN_TO_FILL** is taken when the output accepts cell W*H-1.

The boundary configuration is captured when the first cell of a frame is accepted. The fixed extra latency is the localparam `STAGE_LATENCY` = W*H cycles.

Top module: `stencil_stage`

## Requirements
- R1: While reset is held and after it is released, the stage is in FILL: `in_ready` is 1 and `out_valid` is 0.
- R2: For a fixed edge, every neighbour lying outside the grid across that edge contributes zero. `edge_wrap` bit encoding: bit 0 west (x-1), bit 1 east (x+1), bit 2 north (y-1), bit 3 south (y+1); 0 means fixed, 1 means periodic.
- R3: With the west bit set, the west neighbour of column 0 is column W-1 of the same row. With the east bit set, the east neighbour of column W-1 is column 0.
- R4: With the north bit set, the north neighbour of row 0 is row H-1 in the same column. With the south bit set, the south neighbour of row H-1 is row 0.
- R5: With 16-bit signed values p (present), q (previous) and c (coefficient, FRAC=8 fractional bits), the new value is 2p - q + floor(c*(N+S+E+W-4p) / 2^FRAC). The result saturates to the range -32768..32767.
- R6: Each output record carries the new value as present, the old present as previous and the unchanged coefficient. Records leave in input raster order.
- R7: `out_last` is 1 exactly on the output record of cell W*H-1. After that record is accepted, the stage returns to FILL.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output record and `out_last` hold steady, and no cell is lost or repeated.
- R9: One cycle after cell W*H-1 (marked by `in_last`) is accepted, `out_valid` is 1 and `in_ready` is 0. Input is refused for the whole drain.
- R10: `edge_wrap` is sampled when cell 0 of a frame is accepted. Changes to it later in the frame have no effect on that frame.
- R11: Two stages chained output to input produce the field after two time steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_wrap | input | 4 | Per-edge boundary selection, 1 = periodic |
| in_valid | input | 1 | Input record present |
| in_ready | output | 1 | Stage accepts input (FILL) |
| in_present | input | 16 | Present value of the cell |
| in_previous | input | 16 | Previous value of the cell |
| in_coef | input | 16 | Per-cell update coefficient |
| in_last | input | 1 | Marks the last cell of the frame |
| out_valid | output | 1 | Output record present (DRAIN) |
| out_ready | input | 1 | Downstream accepts the output record |
| out_present | output | 16 | Updated value |
| out_previous | output | 16 | Value before the update |
| out_coef | output | 16 | Coefficient passed through |
| out_last | output | 1 | Marks the last output cell of the frame |

## Verification
The output fields come combinationally from the stored frame and the drain counters. A result offered at an output handshake is therefore due in the same cycle as `out_valid`. The bench samples it one time unit after the falling edge, before the accepting rising edge.

The DRAIN state begins on the rising edge that accepts the last input cell. The bench checks `out_valid` and `in_ready` at the next falling edge, which is one cycle after that acceptance. Stalls come from a randomly deasserted `out_ready`. Each stalled cycle is compared with the following cycle to confirm the record held.

// File: rtl/stencil_stage_pkg.sv
package stencil_stage_pkg;

    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } stage_state_e;

    localparam int DIR_W    = 0;
    localparam int DIR_E    = 1;
    localparam int DIR_N    = 2;
    localparam int DIR_S    = 3;
    localparam int NUM_DIRS = 4;

endpackage

// File: rtl/stencil_frame_store.sv
module stencil_frame_store
    import stencil_stage_pkg::*;
#(
    parameter int CELLS = 24,
    parameter int DW    = 16,
    parameter int AW    = 5
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic signed [DW-1:0] wr_pres,
    input  logic signed [DW-1:0] wr_prev,
    input  logic signed [DW-1:0] wr_coef,
    input  logic [AW-1:0]        ctr_addr,
    output logic signed [DW-1:0] ctr_pres,
    output logic signed [DW-1:0] ctr_prev,
    output logic signed [DW-1:0] ctr_coef,
    input  logic [AW-1:0]        nbr_addr [NUM_DIRS],
    output logic signed [DW-1:0] nbr_pres [NUM_DIRS]
);

    logic signed [DW-1:0] pres_mem [CELLS];
    logic signed [DW-1:0] prev_mem [CELLS];
    logic signed [DW-1:0] coef_mem [CELLS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            pres_mem[wr_addr] <= wr_pres;
            prev_mem[wr_addr] <= wr_prev;
            coef_mem[wr_addr] <= wr_coef;
        end
    end

    assign ctr_pres = pres_mem[ctr_addr];
    assign ctr_prev = prev_mem[ctr_addr];
    assign ctr_coef = coef_mem[ctr_addr];

    for (genvar k = 0; k < NUM_DIRS; k++) begin : g_nbr_rd
        assign nbr_pres[k] = pres_mem[nbr_addr[k]];
    end

endmodule

// File: rtl/stencil_nbr_addr.sv
module stencil_nbr_addr
    import stencil_stage_pkg::*;
#(
    parameter int W  = 6,
    parameter int H  = 4,
    parameter int AW = 5,
    parameter int XW = 3,
    parameter int YW = 2
) (
    input  logic [XW-1:0] col,
    input  logic [YW-1:0] row,
    input  logic [3:0]    wrap,
    output logic [AW-1:0] ctr_addr,
    output logic [AW-1:0] nbr_addr [NUM_DIRS],
    output logic          nbr_use  [NUM_DIRS]
);

    int xi, yi, xw, xe, yn, ys;

    always_comb begin
        xi = int'(col);
        yi = int'(row);
        xw = (xi == 0)     ? W - 1 : xi - 1;
        xe = (xi == W - 1) ? 0     : xi + 1;
        yn = (yi == 0)     ? H - 1 : yi - 1;
        ys = (yi == H - 1) ? 0     : yi + 1;

        ctr_addr        = AW'(yi * W + xi);
        nbr_addr[DIR_W] = AW'(yi * W + xw);
        nbr_addr[DIR_E] = AW'(yi * W + xe);
        nbr_addr[DIR_N] = AW'(yn * W + xi);
        nbr_addr[DIR_S] = AW'(ys * W + xi);

        nbr_use[DIR_W] = (xi != 0)     || wrap[DIR_W];
        nbr_use[DIR_E] = (xi != W - 1) || wrap[DIR_E];
        nbr_use[DIR_N] = (yi != 0)     || wrap[DIR_N];
        nbr_use[DIR_S] = (yi != H - 1) || wrap[DIR_S];
    end

endmodule

// File: rtl/stencil_update.sv
module stencil_update
    import stencil_stage_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 8
) (
    input  logic signed [DW-1:0] pres,
    input  logic signed [DW-1:0] prev,
    input  logic signed [DW-1:0] coef,
    input  logic signed [DW-1:0] nbr [NUM_DIRS],
    output logic signed [DW-1:0] nxt
);

    localparam int PW = 2 * DW + 8;
    localparam logic signed [PW-1:0] SAT_HI = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] SAT_LO = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    function automatic logic signed [PW-1:0] sx(input logic signed [DW-1:0] v);
        return {{(PW-DW){v[DW-1]}}, v};
    endfunction

    logic signed [PW-1:0] lap, prod, scaled, acc;

    always_comb begin
        lap = -(sx(pres) <<< 2);
        for (int k = 0; k < NUM_DIRS; k++) begin
            lap = lap + sx(nbr[k]);
        end
        prod   = lap * sx(coef);
        scaled = prod >>> FRAC;
        acc    = (sx(pres) <<< 1) - sx(prev) + scaled;
        if (acc > SAT_HI) begin
            nxt = SAT_HI[DW-1:0];
        end else if (acc < SAT_LO) begin
            nxt = SAT_LO[DW-1:0];
        end else begin
            nxt = acc[DW-1:0];
        end
    end

endmodule

// File: rtl/stencil_stage.sv
module stencil_stage
    import stencil_stage_pkg::*;
#(
    parameter int W    = 6,
    parameter int H    = 4,
    parameter int DW   = 16,
    parameter int FRAC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           edge_wrap,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] in_present,
    input  logic signed [DW-1:0] in_previous,
    input  logic signed [DW-1:0] in_coef,
    input  logic                 in_last,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic signed [DW-1:0] out_present,
    output logic signed [DW-1:0] out_previous,
    output logic signed [DW-1:0] out_coef,
    output logic                 out_last
);

    localparam int CELLS         = W * H;
    localparam int AW            = $clog2(CELLS);
    localparam int XW            = $clog2(W);
    localparam int YW            = $clog2(H);
    localparam int STAGE_LATENCY = CELLS;

    stage_state_e state_q, state_d;

    logic [AW-1:0] wr_idx;
    logic [XW-1:0] rd_col;
    logic [YW-1:0] rd_row;
    logic [3:0]    mode_q;

    logic in_fire, out_fire, wr_done, rd_at_end, rd_done;

    logic [AW-1:0]        ctr_addr;
    logic [AW-1:0]        nbr_addr [NUM_DIRS];
    logic                 nbr_use  [NUM_DIRS];
    logic signed [DW-1:0] nbr_raw  [NUM_DIRS];
    logic signed [DW-1:0] nbr_val  [NUM_DIRS];
    logic signed [DW-1:0] ctr_pres, ctr_prev, ctr_coef, nxt;

    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;
    assign wr_done   = in_fire && (int'(wr_idx) == CELLS - 1);
    assign rd_at_end = (int'(rd_col) == W - 1) && (int'(rd_row) == H - 1);
    assign rd_done   = out_fire && rd_at_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: FILL_TO_DRAIN, DRAIN_TO_FILL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:  if (wr_done) state_d = ST_DRAIN;
            ST_DRAIN: if (rd_done) state_d = ST_FILL;
        endcase
    end

    // state outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_FILL:  in_ready  = 1'b1;
            ST_DRAIN: out_valid = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            mode_q <= '0;
        end else if (in_fire) begin
            wr_idx <= wr_done ? '0 : wr_idx + 1'b1;
            if (wr_idx == '0) begin
                mode_q <= edge_wrap;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_col <= '0;
            rd_row <= '0;
        end else if (out_fire) begin
            if (int'(rd_col) == W - 1) begin
                rd_col <= '0;
                rd_row <= (int'(rd_row) == H - 1) ? '0 : rd_row + 1'b1;
            end else begin
                rd_col <= rd_col + 1'b1;
            end
        end
    end

    stencil_frame_store #(.CELLS(CELLS), .DW(DW), .AW(AW)) store_i (
        .clk      (clk),
        .wr_en    (in_fire),
        .wr_addr  (wr_idx),
        .wr_pres  (in_present),
        .wr_prev  (in_previous),
        .wr_coef  (in_coef),
        .ctr_addr (ctr_addr),
        .ctr_pres (ctr_pres),
        .ctr_prev (ctr_prev),
        .ctr_coef (ctr_coef),
        .nbr_addr (nbr_addr),
        .nbr_pres (nbr_raw)
    );

    stencil_nbr_addr #(.W(W), .H(H), .AW(AW), .XW(XW), .YW(YW)) addr_i (
        .col      (rd_col),
        .row      (rd_row),
        .wrap     (mode_q),
        .ctr_addr (ctr_addr),
        .nbr_addr (nbr_addr),
        .nbr_use  (nbr_use)
    );

    for (genvar k = 0; k < NUM_DIRS; k++) begin : g_nbr_mask
        assign nbr_val[k] = nbr_use[k] ? nbr_raw[k] : '0;
    end

    stencil_update #(.DW(DW), .FRAC(FRAC)) upd_i (
        .pres (ctr_pres),
        .prev (ctr_prev),
        .coef (ctr_coef),
        .nbr  (nbr_val),
        .nxt  (nxt)
    );

    assign out_present  = nxt;
    assign out_previous = ctr_pres;
    assign out_coef     = ctr_coef;
    assign out_last     = out_valid && rd_at_end;

endmodule

// File: rtl/stencil_stage_checker.sv
module stencil_stage_checker #(
    parameter int DW  = 16,
    parameter int LAT = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_last,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_last,
    input logic [DW-1:0] out_present,
    input logic [DW-1:0] out_previous,
    input logic [DW-1:0] out_coef
);

    int acc_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= 0;
        end else if (in_valid && in_ready) begin
            acc_cnt <= in_last ? 0 : acc_cnt + 1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (in_ready && !out_valid));

    p_frame_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |-> (acc_cnt == LAT - 1));

    p_drain_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> (out_valid && !in_ready));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_present)
            && $stable(out_previous) && $stable(out_coef) && $stable(out_last)));

    p_refill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

endmodule

bind stencil_stage stencil_stage_checker #(.DW(DW), .LAT(STAGE_LATENCY)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_last      (in_last),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_last     (out_last),
    .out_present  (out_present),
    .out_previous (out_previous),
    .out_coef     (out_coef)
);

// File: tb/stencil_stage_tb_top.sv
`timescale 1ns/1ps
module stencil_stage_tb_top;

    localparam int W     = 6;
    localparam int H     = 4;
    localparam int CELLS = W * H;
    localparam int DW    = 16;
    localparam int FRAC  = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic [3:0] wrap1, wrap2;
    logic in_valid, in_ready, in_last;
    logic signed [DW-1:0] in_p, in_q, in_c;
    logic s1_valid, s1_ready, s1_last;
    logic signed [DW-1:0] s1_p, s1_q, s1_c;
    logic out_valid, out_ready, out_last;
    logic signed [DW-1:0] out_p, out_q, out_c;

    stencil_stage #(.W(W), .H(H), .DW(DW), .FRAC(FRAC)) dut_i (
        .clk(clk), .rst_n(rst_n), .edge_wrap(wrap1),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_present(in_p), .in_previous(in_q), .in_coef(in_c), .in_last(in_last),
        .out_valid(s1_valid), .out_ready(s1_ready),
        .out_present(s1_p), .out_previous(s1_q), .out_coef(s1_c), .out_last(s1_last)
    );

    stencil_stage #(.W(W), .H(H), .DW(DW), .FRAC(FRAC)) dut2_i (
        .clk(clk), .rst_n(rst_n), .edge_wrap(wrap2),
        .in_valid(s1_valid), .in_ready(s1_ready),
        .in_present(s1_p), .in_previous(s1_q), .in_coef(s1_c), .in_last(s1_last),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_present(out_p), .out_previous(out_q), .out_coef(out_c), .out_last(out_last)
    );

    int checks = 0;
    int errors = 0;
    int got = 0;
    bit mon_on = 1'b0;
    string cur_tag = "";

    int src_p [CELLS];
    int src_q [CELLS];
    int src_c [CELLS];
    int mp [CELLS];
    int mq [CELLS];
    int np [CELLS];
    int nq [CELLS];
    int exp_p [CELLS];
    int exp_q [CELLS];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int nval(input int x, input int y, input int dir, input logic [3:0] m);
        case (dir)
            0: return (x > 0) ? mp[y*W+x-1] : (m[0] ? mp[y*W+W-1] : 0);
            1: return (x < W-1) ? mp[y*W+x+1] : (m[1] ? mp[y*W] : 0);
            2: return (y > 0) ? mp[(y-1)*W+x] : (m[2] ? mp[(H-1)*W+x] : 0);
            default: return (y < H-1) ? mp[(y+1)*W+x] : (m[3] ? mp[x] : 0);
        endcase
    endfunction

    // one time step of the reference model on mp/mq/src_c into np/nq
    task automatic model_step(input logic [3:0] m);
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                longint p, lap, sh, acc;
                p   = mp[y*W+x];
                lap = longint'(nval(x, y, 0, m)) + nval(x, y, 1, m)
                    + nval(x, y, 2, m) + nval(x, y, 3, m) - 4 * p;
                sh  = (lap * src_c[y*W+x]) >>> FRAC;
                acc = 2 * p - mq[y*W+x] + sh;
                if (acc > 32767) acc = 32767;
                if (acc < -32768) acc = -32768;
                np[y*W+x] = int'(acc);
                nq[y*W+x] = int'(p);
            end
        end
    endtask

    // output monitor with random back-pressure
    logic hold_pend = 1'b0;
    int hold_p, hold_q, hold_c, hold_l;
    initial begin
        out_ready = 1'b0;
        forever begin
            @(negedge clk);
            out_ready = ($urandom % 10) < 7;
            #1;
            if (hold_pend && rst_n) begin
                check(out_valid && out_p == hold_p && out_q == hold_q && out_c == hold_c
                      && int'(out_last) == hold_l, "R8 hold", int'(out_p), hold_p);
            end
            hold_pend = 1'b0;
            if (mon_on && out_valid && !out_ready) begin
                hold_pend = 1'b1;
                hold_p = out_p; hold_q = out_q; hold_c = out_c; hold_l = int'(out_last);
            end
            if (mon_on && out_valid && out_ready) begin
                check(int'(out_p) == exp_p[got], {cur_tag, " R11 cell value"}, int'(out_p), exp_p[got]);
                check(int'(out_q) == exp_q[got] && int'(out_c) == src_c[got], "R6 previous/coef",
                      int'(out_q), exp_q[got]);
                check(out_last == (got == CELLS - 1), "R7 last flag", int'(out_last),
                      int'(got == CELLS - 1));
                got++;
            end
        end
    end

    task automatic run_frame(input logic [3:0] m, input bit sat, input bit toggle, input string tag);
        for (int i = 0; i < CELLS; i++) begin
            if (sat) begin
                int mag;
                mag = 20000 + int'($urandom_range(0, 12767));
                src_p[i] = ($urandom % 2) ? mag : -mag;
                src_q[i] = -src_p[i];
                src_c[i] = int'($urandom_range(200, 255));
            end else begin
                src_p[i] = int'($urandom_range(0, 4000)) - 2000;
                src_q[i] = int'($urandom_range(0, 4000)) - 2000;
                src_c[i] = int'($urandom_range(0, 128));
            end
            mp[i] = src_p[i];
            mq[i] = src_q[i];
        end
        model_step(m);
        for (int i = 0; i < CELLS; i++) begin
            mp[i] = np[i];
            mq[i] = nq[i];
        end
        model_step(m);
        for (int i = 0; i < CELLS; i++) begin
            exp_p[i] = np[i];
            exp_q[i] = nq[i];
        end
        cur_tag = tag;
        got = 0;
        mon_on = 1'b1;
        wrap1 = m;
        wrap2 = m;
        for (int i = 0; i < CELLS; i++) begin
            @(negedge clk);
            if (toggle && i == 1) wrap1 = ~m;   // R10: must be ignored mid-frame
            in_valid = 1'b1;
            in_p = DW'(src_p[i]);
            in_q = DW'(src_q[i]);
            in_c = DW'(src_c[i]);
            in_last = (i == CELLS - 1);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
        #1;
        check(s1_valid && !in_ready, "R9 drain after last", int'(s1_valid), 1);
        while (got < CELLS) @(negedge clk);
        mon_on = 1'b0;
        wrap1 = m;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog expired: actual=%0d expected=%0d", got, CELLS);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        wrap1 = '0;
        wrap2 = '0;
        in_valid = 1'b0;
        in_last = 1'b0;
        in_p = '0;
        in_q = '0;
        in_c = '0;
        repeat (4) @(negedge clk);
        #1;
        check(in_ready && !s1_valid && s1_ready && !out_valid, "R1 reset state",
              int'(in_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(in_ready && !s1_valid && !out_valid, "R1 after release", int'(in_ready), 1);

        run_frame(4'b0000, 1'b0, 1'b0, "R2 fixed");
        run_frame(4'b0011, 1'b0, 1'b0, "R3 x-wrap");
        run_frame(4'b1100, 1'b0, 1'b0, "R4 y-wrap");
        run_frame(4'b1111, 1'b0, 1'b0, "R3 R4 full wrap");
        run_frame(4'b0101, 1'b0, 1'b1, "R10 mode latch");
        run_frame(4'b1010, 1'b0, 1'b1, "R10 mode latch");
        run_frame(4'b1111, 1'b1, 1'b0, "R5 saturate");
        run_frame(4'b0000, 1'b1, 1'b0, "R5 R2 saturate");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule